// File: doc/BRIEF.md
# Sized-Access General Register File

This block holds eight 16-bit general registers. It has one synchronous write port and two independent combinational read ports. Every access carries a size code: byte, BCD, word or longword. Narrow writes (byte and BCD) replace only bits 7..0 of the target register and keep bits 15..8. A word write replaces the whole register. A longword occupies a register pair. Its high half lives in the even register n and its low half in register n+1.

Each read port returns data already shaped for its size on a 32-bit bus:

- A narrow read returns the low byte, zero-extended.
- A word read returns the register, zero-extended.
- A longword read returns the pair concatenated as {Rn, Rn+1}.

A longword access that names an odd register is illegal. On the write port such an access is dropped. On a read port it returns zero. In both cases it raises a shared `illegalReg` flag in the same cycle.

Size codes on `wrSize`, `rdSizeA` and `rdSizeB` are: 0 = byte, 1 = BCD, 2 = word, 3 = longword. Bit 15 is the most significant bit of a register.

Top module: `sized_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to zero.
- R2: A byte write (size 0) to register k loads `wrData[7:0]` into bits 7..0 of Rk and leaves bits 15..8 of Rk unchanged.
- R3: A BCD write (size 1) behaves like a byte write. A BCD read returns the tens digit in bits 7..4 and the units digit in bits 3..0 of the read bus, with bits 31..8 zero.
- R4: A word write (size 2) to register k loads `wrData[15:0]` into all 16 bits of Rk.
- R5: A longword write (size 3) with even index n loads `wrData[31:16]` into Rn and `wrData[15:0]` into Rn+1.
- R6: A longword write with odd index drives `illegalReg` high in that cycle and leaves every register unchanged.
- R7: Writes take effect at the rising clock edge. A read in the following cycle returns the new value.
- R8: A byte or BCD read returns bits 7..0 of the register, zero-extended to 32 bits. A word read returns the register, zero-extended to 32 bits.
- R9: A longword read with even index n returns {Rn, Rn+1}.
- R10: A longword read with odd index on either read port returns zero on that port and drives `illegalReg` high.
- R11: The two read ports address registers and sizes independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrSize | input | 2 | Write size code |
| wrIdx | input | 3 | Write register index (pair base for longword) |
| wrData | input | 32 | Write data; longword uses all 32 bits, word the low 16, narrow the low 8 |
| rdSizeA | input | 2 | Read port A size code |
| rdIdxA | input | 3 | Read port A register index |
| rdDataA | output | 32 | Read port A shaped data |
| rdSizeB | input | 2 | Read port B size code |
| rdIdxB | input | 3 | Read port B register index |
| rdDataB | output | 32 | Read port B shaped data |
| illegalReg | output | 1 | Odd index used with a longword access on any port |

## Verification
The hardest case to observe is the one that must leave no trace: a longword write with an odd pair index. It has to change nothing in any of the eight registers. To expose it, the bench first fills every register with a distinct word, so that a stray write to either half of any pair would be visible. It then issues the odd-index writes with data that differs from every stored value. After each one it sweeps both read ports over all eight registers and compares them with an arithmetic model. Preserving the upper byte on narrow writes is exposed the same way: the narrow writes land on registers whose upper bytes are already nonzero and distinct.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_BCD  = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } accSize_e;

  // Write strobes handed from control to datapath
  typedef struct packed {
    logic       upperEn;   // write bits 15..8 of the selected register(s)
    logic       lowerEn;   // write bits 7..0 of the selected register(s)
    logic       pairMode;  // longword: base gets high half, base+1 gets low half
    logic [2:0] baseIdx;
  } wrStrobe_t;

endpackage

// File: rtl/rf_control.sv
module rf_control
  import regfile_pkg::*;
#(
  parameter int REG_COUNT = 8,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic             wrEn,
  input  logic [1:0]       wrSize,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [1:0]       rdSizeA,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [1:0]       rdSizeB,
  input  logic [IDX_W-1:0] rdIdxB,
  output wrStrobe_t        strobes,
  output logic             rdBadA,
  output logic             rdBadB,
  output logic             illegalReg
);

  logic wrBad;
  logic wrNarrow;

  always_comb begin
    wrBad    = (wrSize == SZ_LONG) && wrIdx[0];
    wrNarrow = (wrSize == SZ_BYTE) || (wrSize == SZ_BCD);
    rdBadA   = (rdSizeA == SZ_LONG) && rdIdxA[0];
    rdBadB   = (rdSizeB == SZ_LONG) && rdIdxB[0];

    strobes.lowerEn  = wrEn && !wrBad;
    strobes.upperEn  = wrEn && !wrBad && !wrNarrow;
    strobes.pairMode = (wrSize == SZ_LONG);
    strobes.baseIdx  = wrIdx;

    illegalReg = (wrEn && wrBad) || rdBadA || rdBadB;
  end

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import regfile_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int REG_WIDTH = 16,
  localparam int IDX_W  = $clog2(REG_COUNT),
  localparam int HALF_W = REG_WIDTH / 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  wrStrobe_t                           strobes,
  input  logic [2*REG_WIDTH-1:0]              wrData,
  output logic [REG_COUNT-1:0][REG_WIDTH-1:0] regFile
);

  logic [REG_COUNT-1:0] hitReg;
  logic [REG_COUNT-1:0] upperWr;
  logic [REG_COUNT-1:0] lowerWr;

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
    logic [REG_WIDTH-1:0] srcWord;

    always_comb begin
      hitReg[k] = (strobes.baseIdx == IDX_W'(k)) ||
                  (strobes.pairMode && ({strobes.baseIdx[IDX_W-1:1], 1'b1} == IDX_W'(k)));
      upperWr[k] = hitReg[k] && strobes.upperEn;
      lowerWr[k] = hitReg[k] && strobes.lowerEn;
      if (strobes.pairMode && !k[0])
        srcWord = wrData[2*REG_WIDTH-1:REG_WIDTH];
      else
        srcWord = wrData[REG_WIDTH-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        regFile[k] <= '0;
      end else begin
        if (upperWr[k]) regFile[k][REG_WIDTH-1:HALF_W] <= srcWord[REG_WIDTH-1:HALF_W];
        if (lowerWr[k]) regFile[k][HALF_W-1:0]         <= srcWord[HALF_W-1:0];
      end
    end

    // R2: narrow write keeps the upper half of the target
    assert_upper_kept_R2: assert property (@(posedge clk) disable iff (rst)
      (lowerWr[k] && !upperWr[k]) |=> $stable(regFile[k][REG_WIDTH-1:HALF_W]));

    // R4: full single-register write lands entirely
    assert_word_write_R4: assert property (@(posedge clk) disable iff (rst)
      (upperWr[k] && !strobes.pairMode) |=> (regFile[k] == $past(wrData[REG_WIDTH-1:0])));
  end

  // R1: reset clears storage
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (regFile == '0));

  // R5: longword halves land in the even/odd pair
  assert_pair_high_R5: assert property (@(posedge clk) disable iff (rst)
    (strobes.pairMode && strobes.upperEn) |=>
      (regFile[$past(strobes.baseIdx)] == $past(wrData[2*REG_WIDTH-1:REG_WIDTH])));
  assert_pair_low_R5: assert property (@(posedge clk) disable iff (rst)
    (strobes.pairMode && strobes.upperEn) |=>
      (regFile[$past(strobes.baseIdx) + IDX_W'(1)] == $past(wrData[REG_WIDTH-1:0])));

  // R6: at most a pair of registers is touched in one cycle
  assert_touch_limit_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(lowerWr) <= 2);

endmodule

// File: rtl/rf_read_shaper.sv
module rf_read_shaper
  import regfile_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int REG_WIDTH = 16,
  localparam int IDX_W  = $clog2(REG_COUNT),
  localparam int HALF_W = REG_WIDTH / 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [REG_COUNT-1:0][REG_WIDTH-1:0] regFile,
  input  logic [1:0]                          rdSize,
  input  logic [IDX_W-1:0]                    rdIdx,
  input  logic                                rdBad,
  output logic [2*REG_WIDTH-1:0]              rdData
);

  logic [REG_WIDTH-1:0] selWord;
  logic [REG_WIDTH-1:0] mateWord;

  always_comb begin
    selWord  = regFile[rdIdx];
    mateWord = regFile[{rdIdx[IDX_W-1:1], 1'b1}];
    rdData   = '0;
    if (!rdBad) begin
      case (accSize_e'(rdSize))
        SZ_BYTE, SZ_BCD: rdData[HALF_W-1:0]    = selWord[HALF_W-1:0];
        SZ_WORD:         rdData[REG_WIDTH-1:0] = selWord;
        SZ_LONG:         rdData                = {selWord, mateWord};
        default:         rdData                = '0;
      endcase
    end
  end

  // R8: narrow reads are zero-extended
  assert_narrow_zext_R8: assert property (@(posedge clk) disable iff (rst)
    (rdSize[1] == 1'b0) |-> (rdData[2*REG_WIDTH-1:HALF_W] == '0));

  // R10: an illegal pair index yields zero data
  assert_bad_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rdBad |-> (rdData == '0));

endmodule

// File: rtl/sized_regfile.sv
module sized_regfile
  import regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  wrSize,
  input  logic [2:0]  wrIdx,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdSizeA,
  input  logic [2:0]  rdIdxA,
  output logic [31:0] rdDataA,
  input  logic [1:0]  rdSizeB,
  input  logic [2:0]  rdIdxB,
  output logic [31:0] rdDataB,
  output logic        illegalReg
);

  localparam int REG_COUNT = 8;
  localparam int REG_WIDTH = 16;

  wrStrobe_t                           strobes;
  logic                                rdBadA;
  logic                                rdBadB;
  logic [REG_COUNT-1:0][REG_WIDTH-1:0] regFile;

  rf_control #(.REG_COUNT(REG_COUNT)) u_ctrl (
    .wrEn(wrEn), .wrSize(wrSize), .wrIdx(wrIdx),
    .rdSizeA(rdSizeA), .rdIdxA(rdIdxA),
    .rdSizeB(rdSizeB), .rdIdxB(rdIdxB),
    .strobes(strobes), .rdBadA(rdBadA), .rdBadB(rdBadB),
    .illegalReg(illegalReg)
  );

  rf_datapath #(.REG_COUNT(REG_COUNT), .REG_WIDTH(REG_WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData), .regFile(regFile)
  );

  rf_read_shaper #(.REG_COUNT(REG_COUNT), .REG_WIDTH(REG_WIDTH)) u_rdA (
    .clk(clk), .rst(rst), .regFile(regFile),
    .rdSize(rdSizeA), .rdIdx(rdIdxA), .rdBad(rdBadA), .rdData(rdDataA)
  );

  rf_read_shaper #(.REG_COUNT(REG_COUNT), .REG_WIDTH(REG_WIDTH)) u_rdB (
    .clk(clk), .rst(rst), .regFile(regFile),
    .rdSize(rdSizeB), .rdIdx(rdIdxB), .rdBad(rdBadB), .rdData(rdDataB)
  );

  // R6: odd-index longword write raises the flag in the same cycle
  assert_odd_write_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrSize == 2'd3) && wrIdx[0]) |-> illegalReg);

  // R10: odd-index longword read raises the flag
  assert_odd_read_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (((rdSizeA == 2'd3) && rdIdxA[0]) || ((rdSizeB == 2'd3) && rdIdxB[0])) |-> illegalReg);

endmodule

// File: tb/sim_sized_regfile.sv
module sim_sized_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSize = 2'd2;
  logic [2:0]  wrIdx = 3'd0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSizeA = 2'd2;
  logic [2:0]  rdIdxA = 3'd0;
  logic [31:0] rdDataA;
  logic [1:0]  rdSizeB = 2'd2;
  logic [2:0]  rdIdxB = 3'd0;
  logic [31:0] rdDataB;
  logic        illegalReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model [8];

  always #4 clk = ~clk;

  sized_regfile u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSize(wrSize), .wrIdx(wrIdx), .wrData(wrData),
    .rdSizeA(rdSizeA), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdSizeB(rdSizeB), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .illegalReg(illegalReg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] sz, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSize = sz; wrIdx = idx; wrData = d;
    rdSizeA = 2'd2; rdSizeB = 2'd2;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic setReads(input logic [1:0] sa, input logic [2:0] ia,
                          input logic [1:0] sb, input logic [2:0] ib);
    @(negedge clk);
    rdSizeA = sa; rdIdxA = ia; rdSizeB = sb; rdIdxB = ib;
    #1;
  endtask

  task automatic sweepWords(input string req);
    for (int k = 0; k < 8; k++) begin
      setReads(2'd2, 3'(k), 2'd2, 3'(7 - k));
      check(req, rdDataA, {16'h0, model[k]});
      check(req, rdDataB, {16'h0, model[7 - k]});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = 16'h0;
    sweepWords("R1 reset");
    check("R1 flag", {31'b0, illegalReg}, 32'h0);

    // Word writes, read back next cycle (R4, R7, R8, R11)
    for (int k = 0; k < 8; k++) begin
      logic [15:0] w;
      w = 16'hA000 + 16'(k) * 16'h0213 + 16'h0100;
      doWrite(2'd2, 3'(k), {16'hDEAD, w});
      model[k] = w;
      setReads(2'd2, 3'(k), 2'd0, 3'(k));
      check("R4 R7 word", rdDataA, {16'h0, w});
      check("R8 R11 byte zext", rdDataB, {24'h0, w[7:0]});
    end

    // Byte writes keep upper half (R2)
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = 8'h30 + 8'(k) * 8'd7;
      doWrite(2'd0, 3'(k), {24'hFFFFFF, b});
      model[k][7:0] = b;
      setReads(2'd2, 3'(k), 2'd0, 3'(k));
      check("R2 byte", rdDataA, {16'h0, model[k]});
      check("R8 byte read", rdDataB, {24'h0, b});
    end

    // BCD writes (R3)
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = {4'(k), 4'(9 - k)};
      doWrite(2'd1, 3'(k), {24'h5A5A5A, b});
      model[k][7:0] = b;
      setReads(2'd1, 3'(k), 2'd2, 3'(k));
      check("R3 bcd digits", rdDataA, {24'h0, 4'(k), 4'(9 - k)});
      check("R3 R2 upper kept", rdDataB, {16'h0, model[k]});
    end

    // Longword writes to even pairs (R5, R9)
    for (int n = 0; n < 8; n += 2) begin
      logic [31:0] l;
      l = 32'h1357_2468 + 32'(n) * 32'h0101_0111;
      doWrite(2'd3, 3'(n), l);
      model[n] = l[31:16]; model[n + 1] = l[15:0];
      setReads(2'd3, 3'(n), 2'd2, 3'(n + 1));
      check("R9 long read", rdDataA, l);
      check("R5 low half", rdDataB, {16'h0, l[15:0]});
      check("R10 even flag", {31'b0, illegalReg}, 32'h0);
    end

    // Fill with distinct words, then odd longword writes must not touch anything (R6)
    for (int k = 0; k < 8; k++) begin
      doWrite(2'd2, 3'(k), {16'h0, 16'h4C00 + 16'(k) * 16'h1111});
      model[k] = 16'h4C00 + 16'(k) * 16'h1111;
    end
    for (int n = 1; n < 8; n += 2) begin
      @(negedge clk);
      wrEn = 1'b1; wrSize = 2'd3; wrIdx = 3'(n); wrData = 32'hF0F0_0F0F;
      rdSizeA = 2'd2; rdSizeB = 2'd2;
      #1 check("R6 odd write flag", {31'b0, illegalReg}, 32'h1);
      @(posedge clk);
      #1 wrEn = 1'b0;
      sweepWords("R6 no change");
    end

    // Odd longword reads on each port (R10)
    for (int n = 1; n < 8; n += 2) begin
      setReads(2'd3, 3'(n), 2'd2, 3'(n));
      check("R10 port A zero", rdDataA, 32'h0);
      check("R10 flag", {31'b0, illegalReg}, 32'h1);
      check("R11 port B independent", rdDataB, {16'h0, model[n]});
      setReads(2'd0, 3'(n), 2'd3, 3'(n));
      check("R10 port B zero", rdDataB, 32'h0);
      check("R10 flag B", {31'b0, illegalReg}, 32'h1);
    end

    // Mid-run reset (R1)
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = 16'h0;
    sweepWords("R1 second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule